// File: doc/BRIEF.md
# Dual-Phase Serial Word Decoder

This block sits behind a bit-rate sampler and turns a serial stream into parallel words of twenty bits each, least significant bit first. An upstream framer marks the first bit of a word and says whether the word belongs to the video phase or the control phase. Once a word is complete, the block decodes it in the format of its phase and updates one of two output buses.

A video word carries an invert flag, a spare status bit and eighteen encoded symbols. The symbols are complemented when the invert flag is set. A control word carries nine control bits. Five of them arrive three times each and are rebuilt by a 2-of-3 vote, so one corrupted copy per bit does no harm. The other four arrive once and are taken as they are. A data-enable output tells which bus was just refreshed. The bus that was not refreshed keeps its old value. A one-cycle strobe marks each update.

Top module: `dual_phase_word_decoder`

## Requirements
- R1: While reset is asserted, and until the first word completes, pix_out, ctl_out, de_out, en1_out and upd_stb are all zero.
- R2: frame_in high marks the current ser_in bit as bit 0 of a new word. Before the first frame_in no word completes. A frame_in in the middle of a word drops the partial word and restarts alignment.
- R3: After alignment, words follow back to back every 20 clocks with no further frame_in. upd_stb is high for exactly the one cycle after the clock edge that samples bit 19, and strobes are at least 20 cycles apart.
- R4: phase_in is sampled only with bit 0 of each word (1 = video, 0 = control). Its value on the other bits has no effect. de_out takes the sampled phase when the strobe rises and changes at no other time.
- R5: For a video word with bit 0 = 0, pix_out[k] equals word bit k+2 for k = 0..17.
- R6: For a video word with bit 0 = 1, pix_out[k] equals the complement of word bit k+2.
- R7: en1_out takes bit 1 of each video word and holds during control words.
- R8: For a control word, ctl_out[k] for k = 0..4 is the majority of word bits 3k+1, 3k+2 and 3k+3.
- R9: For a control word, ctl_out[5+j] equals word bit 16+j for j = 0..3, with no voting.
- R10: A video word leaves ctl_out unchanged. A control word leaves pix_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit, LSB of word first |
| frame_in | input | 1 | Marks the current bit as bit 0 of a word |
| phase_in | input | 1 | Phase of the word, sampled with bit 0 (1 = video) |
| pix_out | output | 18 | Decoded video symbols |
| ctl_out | output | 9 | Decoded control bits |
| de_out | output | 1 | Phase of the last decoded word |
| en1_out | output | 1 | Status bit 1 of the last video word |
| upd_stb | output | 1 | One-cycle pulse after each decoded word |

## Verification
The hardest case to reach from the ports is a framing pulse arriving mid-word while an earlier alignment is still live. The stimulus starts a framed word, abandons it after a few bits, and then frames a fresh word. It then checks that exactly one strobe follows and that the outputs decode only the fresh word. Every word is also sent with phase_in inverted on all bits except bit 0, which shows that only the sample taken at the boundary counts. The control vectors put one wrong copy into some vote groups and two into others, so the vote is seen both masking an error and flipping the bit.

// File: rtl/dual_phase_word_decoder.sv
module dual_phase_word_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_in,
  input  logic        frame_in,
  input  logic        phase_in,
  output logic [17:0] pix_out,
  output logic [8:0]  ctl_out,
  output logic        de_out,
  output logic        en1_out,
  output logic        upd_stb
);
  localparam int WORD_W  = 20;
  localparam int PIX_W   = 18;
  localparam int CTL_W   = 9;
  localparam int NVOTE   = 5;
  localparam int NPLAIN  = CTL_W - NVOTE;
  localparam int CW      = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-2:0] sreg_q;
  logic [CW-1:0]     cnt_q;
  logic              aligned_q;
  logic              phase_q;

  wire [CW-1:0]     idx      = frame_in ? '0 : cnt_q;
  wire              active   = frame_in | aligned_q;
  wire              last_bit = aligned_q & ~frame_in & (cnt_q == LAST);
  wire [WORD_W-1:0] word     = {ser_in, sreg_q};

  wire [PIX_W-1:0] pix_dec = word[WORD_W-1:2] ^ {PIX_W{word[0]}};
  logic [CTL_W-1:0] ctl_dec;

  for (genvar g = 0; g < NVOTE; g++) begin : g_vote
    wire a = word[3*g+1];
    wire b = word[3*g+2];
    wire c = word[3*g+3];
    assign ctl_dec[g] = (a & b) | (a & c) | (b & c);
  end
  for (genvar j = 0; j < NPLAIN; j++) begin : g_plain
    assign ctl_dec[NVOTE+j] = word[3*NVOTE+1+j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q    <= '0;
      cnt_q     <= '0;
      aligned_q <= 1'b0;
      phase_q   <= 1'b0;
      pix_out   <= '0;
      ctl_out   <= '0;
      de_out    <= 1'b0;
      en1_out   <= 1'b0;
      upd_stb   <= 1'b0;
    end else begin
      sreg_q  <= {ser_in, sreg_q[WORD_W-2:1]};
      upd_stb <= last_bit;
      if (frame_in) aligned_q <= 1'b1;
      if (active) begin
        cnt_q <= (idx == LAST) ? '0 : idx + CW'(1);
        if (idx == '0) phase_q <= phase_in;
      end
      if (last_bit) begin
        de_out <= phase_q;
        if (phase_q) begin
          pix_out <= pix_dec;
          en1_out <= word[1];
        end else begin
          ctl_out <= ctl_dec;
        end
      end
    end
  end

  logic [4:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= 5'd31;
    else if (upd_stb) gap_q <= '0;
    else if (gap_q != 5'd31) gap_q <= gap_q + 5'd1;
  end

  // R3
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> gap_q >= 5'd19);

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R4
  de_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(de_out));

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && de_out) |-> $stable(ctl_out));

  // R10
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !de_out) |-> ($stable(pix_out) && $stable(en1_out)));

  // R2
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(pix_out) && $stable(ctl_out) && $stable(en1_out)));
endmodule

// File: tb/dual_phase_word_decoder_tb.sv
module dual_phase_word_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, frame_in = 1'b0, phase_in = 1'b0;
  logic [17:0] pix_out;
  logic [8:0]  ctl_out;
  logic de_out, en1_out, upd_stb;

  always #2 clk = ~clk;

  dual_phase_word_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_in(frame_in),
    .phase_in(phase_in), .pix_out(pix_out), .ctl_out(ctl_out),
    .de_out(de_out), .en1_out(en1_out), .upd_stb(upd_stb));

  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 20'hABCD4}, {1'b1, 20'h5A5A7}, {1'b0, 20'h0E38F},
    {1'b0, 20'hFFFFE}, {1'b0, 20'h24925}, {1'b1, 20'h00003},
    {1'b0, 20'h00000}, {1'b0, 20'h12345}, {1'b1, 20'hFFFFC},
    {1'b0, 20'hB6DB6}, {1'b1, 20'h80001}, {1'b0, 20'h49248}};

  int n_chk = 0, n_fail = 0;
  logic [17:0] e_pix = '0;
  logic [8:0]  e_ctl = '0;
  logic        e_de = 1'b0, e_en1 = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model(logic ph, logic [19:0] w);
    e_de = ph;
    if (ph) begin
      for (int k = 0; k < 18; k++) e_pix[k] = w[0] ? ~w[k+2] : w[k+2];
      e_en1 = w[1];
    end else begin
      for (int k = 0; k < 5; k++)
        e_ctl[k] = (int'(w[3*k+1]) + int'(w[3*k+2]) + int'(w[3*k+3])) >= 2;
      for (int j = 0; j < 4; j++) e_ctl[5+j] = w[16+j];
    end
  endtask

  task automatic check_outs(string tag);
    chk({tag, " R4 de"}, 32'(de_out), 32'(e_de));
    chk({tag, " R5/R6/R10 pix"}, 32'(pix_out), 32'(e_pix));
    chk({tag, " R8/R9/R10 ctl"}, 32'(ctl_out), 32'(e_ctl));
    chk({tag, " R7 en1"}, 32'(en1_out), 32'(e_en1));
  endtask

  // called at a negedge; returns at the negedge after bit 19 was sampled
  task automatic send_word(logic ph, logic [19:0] w, logic framed);
    for (int i = 0; i < 20; i++) begin
      ser_in   = w[i];
      frame_in = (i == 0) && framed;
      phase_in = (i == 0) ? ph : ~ph;
      @(negedge clk);
      if (i == 1) chk("R3 no strobe mid-word", 32'(upd_stb), 32'd0);
    end
    frame_in = 1'b0;
    chk("R3 strobe after bit 19", 32'(upd_stb), 32'd1);
    model(ph, w);
    check_outs("word");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", 32'(upd_stb), 32'd0);
    check_outs("R1 reset");
    rst_n = 1'b1;
    // R2: unframed traffic produces no word
    for (int i = 0; i < 45; i++) begin
      ser_in = i[0] ^ i[2];
      phase_in = i[1];
      @(negedge clk);
      if (upd_stb !== 1'b0) chk("R2 no strobe before frame", 32'(upd_stb), 32'd0);
    end
    chk("R2 outputs idle before frame", 32'({pix_out, ctl_out, de_out, en1_out}), 32'd0);
    // table: first word framed, rest back to back
    for (int v = 0; v < NV; v++) send_word(VEC[v][20], VEC[v][19:0], v == 0);
    // R2: realign mid-word, partial word dropped
    for (int i = 0; i < 7; i++) begin
      ser_in = 1'b1; frame_in = (i == 0); phase_in = 1'b1;
      @(negedge clk);
    end
    chk("R2 no strobe for dropped partial", 32'(upd_stb), 32'd0);
    send_word(1'b0, 20'h3C7F1, 1'b1);
    send_word(1'b1, 20'h6D2E1, 1'b0);
    // R3: one cycle pulse
    ser_in = 1'b0;
    @(negedge clk);
    chk("R3 strobe one cycle", 32'(upd_stb), 32'd0);
    // R1: reset clears state
    rst_n = 1'b0;
    @(negedge clk);
    e_pix = '0; e_ctl = '0; e_de = 1'b0; e_en1 = 1'b0;
    check_outs("R1 re-reset");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule